// File: doc/BRIEF.md
# Seven-Bit Bidirectional GPIO Port

This block is a small general-purpose I/O port of seven bits sitting on a simple register bus. Software programs a direction register, writes an output data latch, and reads either the levels present on the pins or the latch contents. Each pin gets an output enable and an output value from the block. The pad logic outside turns these into a driven or tri-stated pin. The pin levels come back through a two-flop synchronizer, so a port read shows the pins as they were two clocks earlier.

An external analog-select mask marks pins that are in use by an analog function. Those pins read as zero on the digital read path. The direction register keeps control of their drivers, and software is expected to keep those pins set as inputs. One pin, bit 4 by default, is open-drain: it can only pull low. Because the latch has its own read address, a read-modify-write on the latch works on the value software wrote rather than on pin levels that may be loaded by the board.

Top module: `gpio7_port`

## Requirements
- R1: After reset, the direction register reads 0x7F (all pins inputs), the latch reads 0x00, every pin_oe bit is 0 and every pin_out bit is 0.
- R2: For every pin except the open-drain one, pin_oe is 1 exactly when its direction bit is 0, and pin_out equals its latch bit. A direction write takes effect one clock after the write.
- R3: A write to address 1 (port) or address 2 (latch) loads bits 6:0 of the write data into the same output latch. A read of address 2 returns the latch in bits 6:0.
- R4: A read of address 1 returns in bits 6:0 the pin_in levels sampled two clock edges earlier. The value sampled at only one edge earlier is not yet visible.
- R5: Any pin whose ana_mask bit is 1 reads as 0 at address 1, whatever its level.
- R6: ana_mask has no effect on pin_oe or pin_out. Direction still controls analog-mode pins.
- R7: The open-drain pin (bit OD_BIT, default 4) always has pin_out 0. Its pin_oe is 1 only when its direction bit is 0 and its latch bit is 0.
- R8: Read data bit 7 is always 0. Address 3 reads as 0x00, and writes to address 3 change nothing.
- R9: A read of address 0 returns the direction register in bits 6:0. A write to address 0 loads it from bits 6:0 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 direction, 1 port, 2 latch, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 7 | Raw pin levels from the pads |
| ana_mask | input | 7 | Per-pin analog-mode select from an external control register |
| pin_oe | output | 7 | Per-pin output driver enable |
| pin_out | output | 7 | Per-pin output value |

## Verification
A latch write and a pin edge moving through the synchronizer can fall in the same cycle. The bench changes pin_in on the same clock as a latch write with a different value. It then checks that the latch read shows the written value at once, while the port read shows the new pin levels only on the second edge and never the latch value. The same sweep applies analog masks in the same cycles, to confirm that masking acts only on the port read and never on the drivers.

// File: rtl/gpio7_port.sv
module gpio7_port #(
  parameter int W      = 7,
  parameter int OD_BIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] ana_mask,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out
);
  localparam logic [W-1:0] OD_MASK = W'(1) << OD_BIT;

  logic [W-1:0] dir_q, lat_q, sync1_q, sync2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '1;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (bus_we && bus_addr == 2'd0) dir_q <= bus_wdata[W-1:0];
      if (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) lat_q <= bus_wdata[W-1:0];
    end
  end

  assign pin_oe  = ~dir_q & ~(lat_q & OD_MASK);
  assign pin_out = lat_q & ~OD_MASK;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0:    bus_rdata[W-1:0] = dir_q;
      2'd1:    bus_rdata[W-1:0] = sync2_q & ~ana_mask;
      2'd2:    bus_rdata[W-1:0] = lat_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module gpio7_port_chk #(
  parameter int W      = 7,
  parameter int OD_BIT = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_we,
  input logic [7:0]   bus_wdata,
  input logic [7:0]   bus_rdata,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] ana_mask,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out
);
  localparam logic [W-1:0] PP = ~(W'(1) << OD_BIT);
  logic [1:0] live;

  always_ff @(posedge clk)
    if (!rst_n) live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0) |=> ((pin_oe & PP) == (~$past(bus_wdata[W-1:0]) & PP)));
  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=>
      ((pin_out & PP) == ($past(bus_wdata[W-1:0]) & PP)));
  a_r4_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd2 && bus_addr == 2'd1) |-> (bus_rdata[W-1:0] == ($past(pin_in, 2) & ~ana_mask)));
  a_r5_analog_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> ((bus_rdata[W-1:0] & ana_mask) == '0));
  a_r7_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[OD_BIT] |-> !pin_out[OD_BIT]);
  a_r7_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != 2'd0 && bus_addr != 2'd3 && bus_wdata[OD_BIT]) |=> !pin_oe[OD_BIT]);
  a_r8_top_bit: assert property (@(posedge clk) disable iff (!rst_n) !bus_rdata[7]);
  a_r8_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));
endmodule

bind gpio7_port gpio7_port_chk #(.W(W), .OD_BIT(OD_BIT)) u_chk (.*);

// File: tb/test_gpio7_port.sv
module test_gpio7_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [6:0] pin_in = 0, ana_mask = 0, pin_oe, pin_out;
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  gpio7_port i_gpio7_port (.*);

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    tick();
    bus_we = 0;
  endtask

  function automatic logic [6:0] exp_oe(logic [6:0] d, logic [6:0] l);
    return ~d & ~(l & 7'h10);
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [6:0] prevp;
    @(negedge clk); tick(); rst_n = 1;
    // R1 reset state
    bus_addr = 0; #1 chk("R1 dir", bus_rdata, 8'h7F);
    bus_addr = 2; #1 chk("R1 lat", bus_rdata, 8'h00);
    chk("R1 oe", {1'b0, pin_oe}, 8'h00);
    chk("R1 out", {1'b0, pin_out}, 8'h00);

    // R3/R2/R7: latch sweep with all pins outputs
    wr(0, 8'h00);
    for (int v = 0; v < 128; v++) begin
      wr((v % 2) ? 2'd1 : 2'd2, {1'b1, 7'(v)});
      bus_addr = 2; #1;
      chk("R3 latch read", bus_rdata, {1'b0, 7'(v)});
      chk("R2 out", {1'b0, pin_out}, {1'b0, 7'(v) & 7'h6F});
      chk("R7 oe", {1'b0, pin_oe}, {1'b0, exp_oe(7'h00, 7'(v))});
    end

    // R9/R2/R6/R7: direction sweep under two latch values and masks
    for (int l = 0; l < 2; l++) begin
      wr(2, l ? 8'h7F : 8'h00);
      for (int d = 0; d < 128; d++) begin
        ana_mask = (d % 2) ? 7'h2F : 7'h00;
        wr(0, {1'b1, 7'(d)});
        bus_addr = 0; #1;
        chk("R9 dir read", bus_rdata, {1'b0, 7'(d)});
        chk("R6 oe vs mask", {1'b0, pin_oe}, {1'b0, exp_oe(7'(d), l ? 7'h7F : 7'h00)});
        chk("R7 od out", {7'b0, pin_out[4]}, 8'h00);
      end
    end

    // R4/R5: pin sweep, with a latch write in the same cycle as each pin change
    wr(0, 8'h7F);
    prevp = 7'h00;
    for (int m = 0; m < 4; m++) begin
      logic [6:0] msk;
      msk = (m == 0) ? 7'h00 : (m == 1) ? 7'h2F : (m == 2) ? 7'h7F : 7'h50;
      ana_mask = msk;
      for (int p = 0; p < 128; p++) begin
        pin_in = 7'(p);
        bus_addr = 2; bus_wdata = {1'b0, ~7'(p)}; bus_we = 1;
        tick();
        bus_we = 0;
        #1 chk("R3 latch concurrent", bus_rdata, {1'b0, ~7'(p)});
        bus_addr = 1; #1;
        chk("R4 lag one edge", bus_rdata, {1'b0, prevp & ~msk});
        tick();
        chk("R5 port read", bus_rdata, {1'b0, 7'(p) & ~msk});
        prevp = 7'(p);
      end
    end

    // R8: unused address and bit 7
    wr(2, 8'h2A);
    wr(3, 8'hFF);
    bus_addr = 3; #1 chk("R8 addr3 read", bus_rdata, 8'h00);
    bus_addr = 2; #1 chk("R8 addr3 write ignored lat", bus_rdata, 8'h2A);
    bus_addr = 0; #1 chk("R8 addr3 write ignored dir", bus_rdata, 8'h7F);
    wr(2, 8'hFF);
    bus_addr = 2; #1 chk("R8 bit7 zero", bus_rdata, 8'h7F);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule